// File: doc/BRIEF.md
# Mailbox Command Issue Sequencer

This engine takes one command at a time from a local requester and delivers it to a remote controller through a two-channel doorbell mailbox. When a request is accepted, the engine latches the command ID, sender ID, byte count and payload words. It picks the urgent or the normal channel from the command ID alone. It then copies the payload into that channel's transmit window, rings the channel by writing a packed header word, and waits for the channel's reply doorbell.

When the reply arrives, the engine reads two words from the channel's receive window. The first word is a completion code, which is folded into a 4-bit status. The second word is handed back to the requester. The engine then acknowledges the reply doorbell and reports the result with a single-cycle done pulse. A programmable wait limit ends a request whose reply never comes. Only one request is in flight at any moment, so a channel never carries two outstanding commands.

All mailbox traffic goes over a simple word-addressed bus with single-cycle writes and reads whose data returns one cycle after the read strobe. Channel c occupies the address block starting at c*CH_STRIDE. Inside that block, the transmit window starts at offset 0, the receive window at RX_OFF, the doorbell register at SET_OFF and the acknowledge register at CLR_OFF. The defaults are 64, 16, 32 and 33.

Top module: `mbx_issue_seq`

## Requirements
- R1: `req_ready` is 1 only while the engine is idle. A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `busy` is 1 from the cycle after acceptance through the done cycle, and the engine is idle again in the cycle after done. Out of reset, `busy`, `done`, `bus_wr` and `bus_rd` are 0.
- R2: Command IDs 0x05, 0x06, 0x07, 0x0E, 0x0F, 0x11, 0x12, 0x14, 0x15, 0x16, 0x18, 0x19, 0x1C, 0x1D and 0x1E use channel 1 (urgent). Every other ID uses channel 0.
- R3: The engine writes ceil(size/4) payload words, capped at MAX_WORDS. Word i is bits 32*i+31:32*i of `req_payload` as sampled at acceptance. Word i goes to address base+i, one word per cycle, starting in the cycle after acceptance.
- R4: The header word is cmd in bits 7:0, sender in bits 15:8 and size in bits 28:20, with all other bits 0. It is written to base+SET_OFF in the cycle after the last payload word, or in the cycle after acceptance when no payload word is due.
- R5: While waiting, only `reply_irq[c]` of the selected channel c ends the wait; the other channel's bit has no effect. The cycle after it is seen, the engine reads base+RX_OFF. The next cycle it reads base+RX_OFF+1.
- R6: A first reply word of 0 to 11 becomes that status value. A first reply word of 12 or above becomes status 11.
- R7: Two cycles after the second read, the engine writes 0xFFFFFFFF to base+CLR_OFF.
- R8: In the cycle after the acknowledge write, `done` is 1 for exactly one cycle. In that cycle `done_status` holds the status and `done_word` holds the second reply word.
- R9: With `timeout_cycles` = T ≠ 0, a wait that sees no reply doorbell for T cycles moves straight to done with status 7 and `done_word` 0. No read and no acknowledge write happen in that case. With T = 0 the wait has no limit.
- R10: `bus_wr` and `bus_rd` are never 1 in the same cycle, and the bus is idle while waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine can take a request |
| req_cmd | input | 8 | Command ID |
| req_sender | input | 8 | Sender ID |
| req_size | input | 9 | Transmit byte count |
| req_payload | input | MAX_WORDS*32 | Payload words, word 0 in the low bits |
| timeout_cycles | input | TMO_W | Reply wait limit in cycles, 0 = none |
| reply_irq | input | 2 | Reply doorbell per channel |
| bus_wr | output | 1 | Mailbox write strobe |
| bus_rd | output | 1 | Mailbox read strobe |
| bus_addr | output | ADDR_W | Mailbox word address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, one cycle after `bus_rd` |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 4 | Completion status |
| done_word | output | 32 | Second reply word |

## Verification
Two situations are the hardest to reach from the ports. The first is a reply doorbell on the wrong channel while a request waits. The second is a wait that runs all the way to its limit. The stimulus raises the other channel's doorbell bit for several cycles of a wait, on both channels in turn. It also lets a short nonzero limit expire with no reply while the wrong doorbell toggles. It also runs a long wait with the limit set to zero, to show that no early timeout fires. The channel boundary is reached with IDs next to members of the urgent set (0x04, 0x10, 0x13, 0x1F). The payload cap is reached with sizes 100 and 511.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PAYLOAD,
    ST_RING,
    ST_WAIT,
    ST_READ,
    ST_CLEAR,
    ST_DONE
  } seq_state_e;

  localparam logic [3:0] STAT_TIMEOUT = 4'd7;
  localparam logic [3:0] STAT_DEVICE  = 4'd11;
endpackage

// File: rtl/mbx_chan_sel.sv
module mbx_chan_sel (
  input  logic [7:0] cmd,
  output logic       urgent
);
  always_comb begin
    unique case (cmd)
      8'h05, 8'h06, 8'h07, 8'h0E, 8'h0F,
      8'h11, 8'h12, 8'h14, 8'h15, 8'h16,
      8'h18, 8'h19, 8'h1C, 8'h1D, 8'h1E: urgent = 1'b1;
      default:                           urgent = 1'b0;
    endcase
  end
endmodule

// File: rtl/mbx_hdr_pack.sv
module mbx_hdr_pack (
  input  logic [7:0]  cmd,
  input  logic [7:0]  sender,
  input  logic [8:0]  size,
  output logic [31:0] hdr
);
  assign hdr = {3'b000, size, 4'b0000, sender, cmd};
endmodule

// File: rtl/mbx_status_map.sv
module mbx_status_map
  import mbx_pkg::*;
(
  input  logic [31:0] raw,
  output logic [3:0]  code
);
  always_comb begin
    if (raw >= 32'd12) code = STAT_DEVICE;
    else               code = raw[3:0];
  end

  // R6
  always_comb begin
    code_range_chk: assert (code <= STAT_DEVICE);
  end
endmodule

// File: rtl/mbx_issue_seq.sv
module mbx_issue_seq
  import mbx_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MAX_WORDS = 4,
  parameter int CH_STRIDE = 64,
  parameter int RX_OFF    = 16,
  parameter int SET_OFF   = 32,
  parameter int CLR_OFF   = 33,
  parameter int TMO_W     = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [7:0]              req_cmd,
  input  logic [7:0]              req_sender,
  input  logic [8:0]              req_size,
  input  logic [MAX_WORDS*32-1:0] req_payload,
  input  logic [TMO_W-1:0]        timeout_cycles,
  input  logic [1:0]              reply_irq,
  output logic                    bus_wr,
  output logic                    bus_rd,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [31:0]             bus_wdata,
  input  logic [31:0]             bus_rdata,
  output logic                    busy,
  output logic                    done,
  output logic [3:0]              done_status,
  output logic [31:0]             done_word
);
  localparam int WIDX_W = $clog2(MAX_WORDS + 1);
  localparam int PAY_W  = MAX_WORDS * 32;
  localparam logic [ADDR_W-1:0] A_STRIDE = ADDR_W'(CH_STRIDE);
  localparam logic [ADDR_W-1:0] A_RX     = ADDR_W'(RX_OFF);
  localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(SET_OFF);
  localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(CLR_OFF);

  seq_state_e          state_q, state_d;
  logic                chan_q, chan_d;
  logic [31:0]         hdr_q, hdr_d;
  logic [PAY_W-1:0]    pay_q, pay_d;
  logic [WIDX_W-1:0]   nw_q, nw_d;
  logic [WIDX_W-1:0]   widx_q, widx_d;
  logic [1:0]          rph_q, rph_d;
  logic [TMO_W-1:0]    cnt_q, cnt_d;
  logic [3:0]          stat_q, stat_d;
  logic [31:0]         word_q, word_d;

  logic                sel_urgent;
  logic [31:0]         hdr_new;
  logic [3:0]          mapped;
  logic [9:0]          words_raw;
  logic [WIDX_W-1:0]   words_new;
  logic [ADDR_W-1:0]   base;

  mbx_chan_sel u_sel (.cmd(req_cmd), .urgent(sel_urgent));
  mbx_hdr_pack u_hdr (.cmd(req_cmd), .sender(req_sender), .size(req_size), .hdr(hdr_new));
  mbx_status_map u_map (.raw(bus_rdata), .code(mapped));

  assign words_raw = ({1'b0, req_size} + 10'd3) >> 2;
  assign words_new = (words_raw > 10'(MAX_WORDS)) ? WIDX_W'(MAX_WORDS) : WIDX_W'(words_raw);
  assign base      = chan_q ? A_STRIDE : '0;

  always_comb begin
    state_d   = state_q;
    chan_d    = chan_q;
    hdr_d     = hdr_q;
    pay_d     = pay_q;
    nw_d      = nw_q;
    widx_d    = widx_q;
    rph_d     = rph_q;
    cnt_d     = cnt_q;
    stat_d    = stat_q;
    word_d    = word_q;
    req_ready = 1'b0;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    done      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          chan_d  = sel_urgent;
          hdr_d   = hdr_new;
          pay_d   = req_payload;
          nw_d    = words_new;
          widx_d  = '0;
          state_d = (words_new == '0) ? ST_RING : ST_PAYLOAD;
        end
      end
      ST_PAYLOAD: begin
        bus_wr    = 1'b1;
        bus_addr  = base + ADDR_W'(widx_q);
        bus_wdata = pay_q[int'(widx_q)*32 +: 32];
        widx_d    = widx_q + 1'b1;
        if (widx_q == nw_q - 1'b1) state_d = ST_RING;
      end
      ST_RING: begin
        bus_wr    = 1'b1;
        bus_addr  = base + A_SET;
        bus_wdata = hdr_q;
        cnt_d     = '0;
        state_d   = ST_WAIT;
      end
      ST_WAIT: begin
        if (reply_irq[chan_q]) begin
          rph_d   = 2'd0;
          state_d = ST_READ;
        end else if (timeout_cycles != '0 && cnt_q == timeout_cycles - 1'b1) begin
          stat_d  = STAT_TIMEOUT;
          word_d  = '0;
          state_d = ST_DONE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_READ: begin
        unique case (rph_q)
          2'd0: begin
            bus_rd   = 1'b1;
            bus_addr = base + A_RX;
            rph_d    = 2'd1;
          end
          2'd1: begin
            bus_rd   = 1'b1;
            bus_addr = base + A_RX + 1'b1;
            stat_d   = mapped;
            rph_d    = 2'd2;
          end
          default: begin
            word_d  = bus_rdata;
            state_d = ST_CLEAR;
          end
        endcase
      end
      ST_CLEAR: begin
        bus_wr    = 1'b1;
        bus_addr  = base + A_CLR;
        bus_wdata = '1;
        state_d   = ST_DONE;
      end
      ST_DONE: begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chan_q  <= 1'b0;
      hdr_q   <= '0;
      pay_q   <= '0;
      nw_q    <= '0;
      widx_q  <= '0;
      rph_q   <= '0;
      cnt_q   <= '0;
      stat_q  <= '0;
      word_q  <= '0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
      hdr_q   <= hdr_d;
      pay_q   <= pay_d;
      nw_q    <= nw_d;
      widx_q  <= widx_d;
      rph_q   <= rph_d;
      cnt_q   <= cnt_d;
      stat_q  <= stat_d;
      word_q  <= word_d;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign done_status = stat_q;
  assign done_word   = word_q;

  // R10
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(bus_wr && bus_rd));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && bus_wr));
  // R4
  ring_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && $past(state_q) != ST_WAIT) |-> $past(bus_wr));
  // R9
  wait_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && timeout_cycles != '0) |-> (cnt_q < timeout_cycles));
  // R5
  read_after_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && reply_irq[chan_q]) |=> bus_rd);
endmodule

// File: tb/mbx_issue_seq_tb.sv
module mbx_issue_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready;
  logic [7:0] req_cmd, req_sender;
  logic [8:0] req_size;
  logic [MAXW*32-1:0] req_payload;
  logic [15:0] timeout_cycles;
  logic [1:0] reply_irq;
  logic bus_wr, bus_rd;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic busy, done;
  logic [3:0] done_status;
  logic [31:0] done_word;

  int n_tests = 0;
  int n_fail = 0;
  logic [31:0] mem [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_issue_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_sender(req_sender), .req_size(req_size),
    .req_payload(req_payload), .timeout_cycles(timeout_cycles), .reply_irq(reply_irq),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .busy(busy), .done(done), .done_status(done_status),
    .done_word(done_word)
  );

  // remote-side memory model, read data one cycle after strobe
  always @(posedge clk) begin
    if (bus_rd) bus_rdata <= mem.exists(int'(bus_addr)) ? mem[int'(bus_addr)] : 32'h0;
  end

  function automatic bit is_urgent(int c);
    int lst [15] = '{5, 6, 7, 14, 15, 17, 18, 20, 21, 22, 24, 25, 28, 29, 30};
    foreach (lst[k]) if (lst[k] == c) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string r, bit ok, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  task automatic cyc(string r, bit ewr, bit erd, int eaddr, logic [31:0] ewd, bit eb, bit ed);
    bit ok;
    ok = (bus_wr === ewr) && (bus_rd === erd) && (busy === eb) && (done === ed) && (req_ready === !eb);
    if (ewr || erd) ok = ok && (int'(bus_addr) == eaddr);
    if (ewr) ok = ok && (bus_wdata === ewd);
    check(r, ok, {bus_wr, bus_rd, busy, done, req_ready, bus_addr, bus_wdata},
          {ewr, erd, eb, ed, !eb, 8'(eaddr), ewd});
  endtask

  task automatic run_req(int cmd, int snd, int size, logic [31:0] pl [4],
                         logic [31:0] st_raw, logic [31:0] rw, int dly,
                         bit tmo_case, int tmo, bit other);
    int ch, base, nw, exp_st;
    logic [31:0] hdr;
    ch = is_urgent(cmd) ? 1 : 0;
    base = ch * 64;
    nw = (size + 3) / 4;
    if (nw > MAXW) nw = MAXW;
    hdr = 32'(cmd) + 32'(snd) * 256 + 32'(size) * (1 << 20);
    exp_st = (st_raw >= 12) ? 11 : int'(st_raw);
    mem[base + 16] = st_raw;
    mem[base + 17] = rw;
    timeout_cycles = 16'(tmo);
    cyc("R1", 0, 0, 0, 0, 0, 0);
    req_valid = 1'b1;
    req_cmd = 8'(cmd);
    req_sender = 8'(snd);
    req_size = 9'(size);
    req_payload = {pl[3], pl[2], pl[1], pl[0]};
    @(negedge clk);
    req_valid = 1'b0;
    req_payload = '1;
    req_cmd = 8'hFF;
    for (int i = 0; i < nw; i++) begin
      cyc("R3", 1, 0, base + i, pl[i], 1, 0);
      @(negedge clk);
    end
    cyc("R4 R2", 1, 0, base + 32, hdr, 1, 0);
    @(negedge clk);
    if (tmo_case) begin
      for (int i = 0; i < tmo; i++) begin
        reply_irq = other ? 2'(1 << (1 - ch)) : 2'b00;
        cyc("R9 R10", 0, 0, 0, 0, 1, 0);
        @(negedge clk);
      end
      reply_irq = 2'b00;
      cyc("R9", 0, 0, 0, 0, 1, 1);
      check("R9", done_status == 4'd7 && done_word == 32'h0, {done_status, done_word}, {4'd7, 32'h0});
      @(negedge clk);
    end else begin
      for (int i = 0; i < dly; i++) begin
        reply_irq = other ? 2'(1 << (1 - ch)) : 2'b00;
        cyc("R5 R10", 0, 0, 0, 0, 1, 0);
        @(negedge clk);
      end
      reply_irq = 2'(1 << ch);
      cyc("R5", 0, 0, 0, 0, 1, 0);
      @(negedge clk);
      reply_irq = 2'b00;
      cyc("R5", 0, 1, base + 16, 0, 1, 0);
      @(negedge clk);
      cyc("R5", 0, 1, base + 17, 0, 1, 0);
      @(negedge clk);
      cyc("R7", 0, 0, 0, 0, 1, 0);
      @(negedge clk);
      cyc("R7", 1, 0, base + 33, 32'hFFFF_FFFF, 1, 0);
      @(negedge clk);
      cyc("R8", 0, 0, 0, 0, 1, 1);
      check("R6", int'(done_status) == exp_st, done_status, exp_st);
      check("R8", done_word === rw, done_word, rw);
      @(negedge clk);
    end
    cyc("R1 R8", 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    int cyc_cnt = 0;
    while (cyc_cnt < 100000) begin
      @(posedge clk);
      cyc_cnt++;
    end
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc_cnt);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] p [4];
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_cmd = '0;
    req_sender = '0;
    req_size = '0;
    req_payload = '0;
    timeout_cycles = '0;
    reply_irq = '0;
    repeat (3) @(negedge clk);
    cyc("R1 reset", 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);

    p = '{32'h1111_0000, 32'h2222_0001, 32'h3333_0002, 32'h4444_0003};
    run_req(8'h0E, 8'h21, 8, p, 32'd0, 32'hCAFE_0001, 2, 0, 1000, 0);
    run_req(8'h01, 8'h02, 0, p, 32'd3, 32'h0000_00A5, 0, 0, 1000, 0);
    p = '{32'hDEAD_BEEF, 32'h0BAD_F00D, 32'h5555_AAAA, 32'h0123_4567};
    run_req(8'h13, 8'h7E, 5, p, 32'd12, 32'h1357_9BDF, 3, 0, 1000, 1);
    run_req(8'h1E, 8'hFF, 100, p, 32'hFFFF_FFFF, 32'h8000_0001, 1, 0, 1000, 1);
    run_req(8'h1F, 8'h40, 16, p, 32'd11, 32'h0000_FFFF, 0, 0, 1000, 0);
    run_req(8'h05, 8'h09, 4, p, 32'd0, 32'h1, 0, 1, 6, 1);
    run_req(8'h10, 8'h0A, 7, p, 32'd1, 32'h2468_ACE0, 25, 0, 0, 1);
    run_req(8'h04, 8'hA5, 511, p, 32'd7, 32'h7777_7777, 1, 0, 1000, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule